// File: doc/BRIEF.md
# Ripple-Chain Up/Down Counter

This block is a synchronous binary counter built from a row of identical bit slices. Each slice holds a one-bit full adder and a flip-flop. The flip-flop output feeds back into one input of its adder, and the adder's carry output passes to the next more significant slice. Every cycle the register loads the sum of its own value, a shared addend bit copied into every slice, and a carry seed at the least significant slice.

Two control inputs, a direction select and an enable, are decoded by one inverter and one XNOR gate into the addend bit and the carry seed. The four control combinations give the register plus one, plus all-ones (minus one), plus all-ones plus one, or plus zero. The last two leave the value unchanged modulo 2^N. Counting and holding therefore both come from the adder chain, with no multiplexer in the data path.

The width is a parameter. A second parameter chooses whether the raw carry out of the most significant slice is brought out to a port. An active-high synchronous reset clears the count so that the block can be tested.

Top module: `ripple_updown_counter`

## Requirements
- R1: On a rising clock edge with `rst` high, `count` becomes zero.
- R2: With `rst` low, `count_en` = 1 and `dir_up` = 1, `count` increases by one at the next rising edge.
- R3: With `rst` low, `count_en` = 1 and `dir_up` = 0, `count` decreases by one at the next rising edge.
- R4: With `rst` low and `count_en` = 0, `count` keeps its value at the next rising edge, whatever the value of `dir_up`.
- R5: Counting up from the all-ones value gives zero at the next edge.
- R6: Counting down from zero gives the all-ones value at the next edge.
- R7: With `EXPORT_CARRY` = 1, `carry_out` is a combinational function of the current count and the controls. It is 1 when counting up from all-ones, 1 when counting down from any nonzero value, 0 when holding with `dir_up` = 1, and 1 when holding with `dir_up` = 0. It is 0 in every other case. With `EXPORT_CARRY` = 0 it is always 0.
- R8: `rst` takes priority over `count_en`. A reset edge gives zero even while counting is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous clear |
| count_en | input | 1 | 1 = step the count, 0 = hold |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| count | output | WIDTH | Registered count value |
| carry_out | output | 1 | Raw carry out of the most significant slice (0 when not exported) |

## Verification
The bench builds the block at its default width of four bits with the carry exported. At this size every start value, from zero through all-ones, can be paired with all four control combinations. That sweep covers both wrap-arounds and every row of the carry behaviour for every state. A long random run of direction and enable values is then compared, cycle by cycle, against an arithmetic plus-one/minus-one/hold model.

// File: rtl/udc_pkg.sv
package udc_pkg;

   // Direction encoding carried on the dir_up input.
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } udc_dir_e;

   // Decoded controls that feed the slice chain.
   typedef struct packed {
      logic addend;   // bit driven into every slice's operand input
      logic seed;     // carry into the least significant slice
   } udc_ctrl_t;

   // Width limits checked at elaboration.
   localparam int unsigned UDC_MIN_WIDTH = 1;
   localparam int unsigned UDC_MAX_WIDTH = 1024;

endpackage

// File: rtl/udc_ctrl.sv
module udc_ctrl
   import udc_pkg::*;
(
   input  logic      dir_up,
   input  logic      count_en,
   output udc_ctrl_t ctrl
);

   // Up: add 0 (+1 seed when stepping). Down: add all-ones (+1 seed when
   // holding, which makes a full wrap of 2^N and so leaves the value as it is).
   always_comb begin
      ctrl.addend = ~dir_up;
      ctrl.seed   = ~(dir_up ^ count_en);
   end

endmodule

// File: rtl/udc_full_adder.sv
module udc_full_adder (
   input  logic a_in,
   input  logic b_in,
   input  logic c_in,
   output logic sum,
   output logic c_out
);

   logic half_sum;

   always_comb begin
      half_sum = a_in ^ b_in;
      sum      = half_sum ^ c_in;
      c_out    = (a_in & b_in) | (half_sum & c_in);
   end

endmodule

// File: rtl/udc_slice.sv
module udc_slice (
   input  logic clk,
   input  logic rst,
   input  logic addend,
   input  logic c_in,
   output logic q,
   output logic c_out
);

   logic next_bit;

   udc_full_adder fa_i (
      .a_in  (addend),
      .b_in  (q),
      .c_in  (c_in),
      .sum   (next_bit),
      .c_out (c_out)
   );

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= next_bit;
   end

endmodule

// File: rtl/ripple_updown_counter.sv
module ripple_updown_counter
   import udc_pkg::*;
#(
   parameter int unsigned WIDTH        = 4,
   parameter bit          EXPORT_CARRY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             count_en,
   input  logic             dir_up,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);

   localparam int unsigned CHAIN_LEN = WIDTH + 1;

   if (WIDTH < UDC_MIN_WIDTH || WIDTH > UDC_MAX_WIDTH) begin : g_bad_width
      $error("ripple_updown_counter: WIDTH %0d out of range", WIDTH);
   end

   udc_ctrl_t             ctrl;
   logic [CHAIN_LEN-1:0]  carry_chain;

   udc_ctrl ctrl_i (
      .dir_up   (dir_up),
      .count_en (count_en),
      .ctrl     (ctrl)
   );

   assign carry_chain[0] = ctrl.seed;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      udc_slice slice_i (
         .clk    (clk),
         .rst    (rst),
         .addend (ctrl.addend),
         .c_in   (carry_chain[i]),
         .q      (count[i]),
         .c_out  (carry_chain[i+1])
      );
   end

   if (EXPORT_CARRY) begin : g_carry_out
      assign carry_out = carry_chain[WIDTH];
   end else begin : g_carry_tied
      logic unused_carry;
      assign unused_carry = carry_chain[WIDTH];
      assign carry_out    = 1'b0;
   end

endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
   parameter int unsigned WIDTH        = 4,
   parameter bit          EXPORT_CARRY = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             count_en,
   input logic             dir_up,
   input logic [WIDTH-1:0] count,
   input logic             carry_out
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> count == '0);   // R1 R8

   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (count_en && dir_up) |=> count == WIDTH'($past(count) + 1'b1));   // R2 R5

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (count_en && !dir_up) |=> count == WIDTH'($past(count) - 1'b1));   // R3 R6

   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !count_en |=> $stable(count));   // R4

   AST_CARRY_HOLD_UP: assert property (@(posedge clk) disable iff (rst)
      (!count_en && dir_up) |-> !carry_out);   // R7

   AST_CARRY_HOLD_DOWN: assert property (@(posedge clk) disable iff (rst)
      (!count_en && !dir_up) |-> carry_out == EXPORT_CARRY);   // R7

   AST_CARRY_UP: assert property (@(posedge clk) disable iff (rst)
      (count_en && dir_up) |-> carry_out == (EXPORT_CARRY && count == ALL_ONES));   // R7

   AST_CARRY_DOWN: assert property (@(posedge clk) disable iff (rst)
      (count_en && !dir_up) |-> carry_out == (EXPORT_CARRY && count != '0));   // R7

endmodule

bind ripple_updown_counter udc_checker #(
   .WIDTH        (WIDTH),
   .EXPORT_CARRY (EXPORT_CARRY)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .count_en  (count_en),
   .dir_up    (dir_up),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/ripple_updown_counter_tb_top.sv
module ripple_updown_counter_tb_top;

   localparam int unsigned W       = 4;
   localparam int unsigned SPAN    = 1 << W;
   localparam time         CLK_PER = 10ns;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         count_en = 1'b0;
   logic         dir_up = 1'b1;
   logic [W-1:0] count;
   logic         carry_out;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   ripple_updown_counter #(.WIDTH(W), .EXPORT_CARRY(1'b1)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .count_en  (count_en),
      .dir_up    (dir_up),
      .count     (count),
      .carry_out (carry_out)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Advance one edge; inputs change and outputs are read 1ns after it.
   task automatic tick();
      @(posedge clk);
      #1ns;
   endtask

   task automatic preset(input int v);
      rst = 1'b1; count_en = 1'b0; tick();
      rst = 1'b0; count_en = 1'b1; dir_up = 1'b1;
      for (int k = 0; k < v; k++) tick();
      count_en = 1'b0;
   endtask

   function automatic int carry_model(input int v, input bit up, input bit en);
      if (up && en)  return (v == SPAN-1) ? 1 : 0;
      if (!up && en) return (v != 0) ? 1 : 0;
      if (up)        return 0;
      return 1;
   endfunction

   function automatic int next_model(input int v, input bit up, input bit en);
      if (!en) return v;
      if (up)  return (v + 1) % SPAN;
      return (v + SPAN - 1) % SPAN;
   endfunction

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int model;
      // R1: reset state
      tick();
      check("R1 reset clears count", int'(count), 0);

      // Exhaustive sweep: every start value against every control pair.
      for (int s = 0; s < int'(SPAN); s++) begin
         for (int c = 0; c < 4; c++) begin
            bit up, en;
            int exp_next;
            string tag;
            up = c[1]; en = c[0];
            preset(s);
            check("R2 preset by counting up", int'(count), s);
            dir_up = up; count_en = en;
            #1ns;
            check("R7 carry_out", int'(carry_out), carry_model(s, up, en));
            tick();
            exp_next = next_model(s, up, en);
            if (!en)                            tag = "R4 hold";
            else if (up && s == int'(SPAN)-1)   tag = "R5 wrap up";
            else if (!up && s == 0)             tag = "R6 wrap down";
            else if (up)                        tag = "R2 increment";
            else                                tag = "R3 decrement";
            check(tag, int'(count), exp_next);
            count_en = 1'b0;
         end
      end

      // R8: reset wins over an enabled count
      preset(5);
      rst = 1'b1; count_en = 1'b1; dir_up = 1'b1;
      tick();
      check("R8 reset over enable", int'(count), 0);
      rst = 1'b0; count_en = 1'b0;

      // Random direction/enable run against the arithmetic model.
      model = 0;
      for (int n = 0; n < 600; n++) begin
         bit up, en;
         up = 1'($urandom_range(1, 0));
         en = ($urandom_range(3, 0) != 0);
         dir_up = up; count_en = en;
         #1ns;
         check("R7 carry random", int'(carry_out), carry_model(model, up, en));
         tick();
         model = next_model(model, up, en);
         check(en ? (up ? "R2 random up" : "R3 random down") : "R4 random hold",
               int'(count), model);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule